// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters. A one-clock `tick` enable arrives 16 times per bit period and drives all timing. A falling edge on the line starts a frame. The block checks the start bit, then recovers every data bit and the stop bit by a majority vote over three samples taken near the middle of the bit. Each character is 1 start bit, 8 or 9 data bits sent LSB first, and 1 stop bit. The result goes into a 9-bit data register, and a receive-full flag is raised that the host clears with a read strobe.

On a multidrop line, a receiver that is not addressed can go into standby. In standby it still writes each character it receives into the data register. It does not raise the receive-full flag, and its interrupt is masked. Standby ends on its own in one of two ways, picked by an input:
- the line has stayed idle for a whole frame, or
- a received character has its top bit set, marking it as an address.

The host sets standby with a request pulse.

Top module: `uart_rx_standby`

## Requirements
- R1: With `nine_bit`=0, a frame with data bits d0..d7 (LSB first) loads `rx_data` = {1'b0, d7..d0}. The load happens on the tick at RT10 of the stop bit, which is the 154th tick counting the start-edge tick as tick 1.
- R2: With `nine_bit`=1, a frame with 9 data bits loads `rx_data` = {d8..d0} on the 170th tick.
- R3: Each data and stop bit takes the majority of its samples at RT8, RT9 and RT10. `noise_err` is updated on each load and is set if the three samples of any data or stop bit in that character disagree.
- R4: A start is a low sample that follows a high sample while idle. Samples at RT3, RT5 and RT7 check it. If two or more of them are high, the frame is dropped and nothing is loaded.
- R5: If the majority of the stop-bit samples is low, `frame_err` is set on load, and the character is still loaded.
- R6: A stop bit that lasts only through RT10 is accepted. A new start edge on the very next tick begins the next frame.
- R7: A load outside standby sets `rx_full`. A `rd_strobe` pulse clears `rx_full` and `overrun`. `rx_irq` is high when `rx_full` is high and standby is off.
- R8: If a character completes while `rx_full` is high and standby is off, `overrun` is set, and `rx_data` and the error flags keep their old values.
- R9: A `stby_req` pulse sets `standby`. In standby, completed characters are loaded into `rx_data` and the error flags, but `rx_full` and `overrun` are left unchanged, and `rx_irq` is low.
- R10: With `wake_sel`=1, a character that completes in standby with its top bit set clears `standby` and is received normally. The top bit is bit 8 when `nine_bit`=1 and bit 7 when `nine_bit`=0.
- R11: With `wake_sel`=0, `standby` clears on the 160th tick (176th when `nine_bit`=1) in a row on which the receiver is idle and the line is high. The count restarts at each `stby_req`.
- R12: After reset, `rx_data`, `rx_full`, `rx_irq`, `noise_err`, `frame_err`, `overrun` and `standby` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversample enable, 16 per bit period |
| line_in | input | 1 | Asynchronous serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_sel | input | 1 | Standby exit: 0 = idle line, 1 = address mark |
| stby_req | input | 1 | Pulse that enters standby |
| rd_strobe | input | 1 | Pulse that clears `rx_full` and `overrun` |
| rx_data | output | 9 | Last loaded character |
| rx_full | output | 1 | Receive-full flag |
| rx_irq | output | 1 | Receive interrupt request |
| noise_err | output | 1 | Sample disagreement in last loaded character |
| frame_err | output | 1 | Low stop bit in last loaded character |
| overrun | output | 1 | Character lost because `rx_full` was high |
| standby | output | 1 | Receiver is in standby |

## Verification
The bench sweeps many data values in both character lengths and places the sampling points exactly. A receiver whose tick count is off by one would shift every bit and fail the sweep.

It also targets these corner cases, each with the fault it would expose:
- **Single-sample flip at RT9:** a receiver that trusts one sample would corrupt the data instead of only raising `noise_err`.
- **Three-tick glitch:** a receiver that skips start verification would load a bogus character.
- **Stop bit cut at RT10, followed straight away by a new frame:** a receiver that waits for RT16 would lose the second start edge.
- **Standby:**
  - A flag leak would raise `rx_full` or `overrun` for foreign traffic.
  - A wrong top-bit choice would wake on the wrong character.
  - An idle counter one tick off would flip `standby` one tick early or late at the 160/176 boundary.

// File: rtl/uart_rx_standby.sv
module uart_rx_standby (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic       nine_bit,
  input  logic       wake_sel,
  input  logic       stby_req,
  input  logic       rd_strobe,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       rx_irq,
  output logic       noise_err,
  output logic       frame_err,
  output logic       overrun,
  output logic       standby
);
  localparam logic [7:0] IDLE_FT8 = 8'd160;
  localparam logic [7:0] IDLE_FT9 = 8'd176;

  logic [1:0] sync;
  logic       busy, prev_high, noise_acc;
  logic [7:0] cnt, idle_cnt;
  logic [1:0] smp;
  logic [8:0] sh;

  wire       line_s   = sync[1];
  wire [3:0] rt0      = cnt[3:0];
  wire [3:0] bitn     = cnt[7:4];
  wire [3:0] last_bit = nine_bit ? 4'd10 : 4'd9;
  wire [7:0] idle_ft  = nine_bit ? IDLE_FT9 : IDLE_FT8;

  wire maj = (smp[1] & smp[0]) | (smp[1] & line_s) | (smp[0] & line_s);
  wire dis = (smp[1] ^ smp[0]) | (smp[0] ^ line_s);

  wire sample_pt  = busy && ((bitn == 4'd0) ? (rt0 == 4'd2 || rt0 == 4'd4)
                                            : (rt0 == 4'd7 || rt0 == 4'd8));
  wire start_eval = busy && bitn == 4'd0 && rt0 == 4'd6;
  wire bit_eval   = busy && bitn != 4'd0 && rt0 == 4'd9;
  wire done       = bit_eval && bitn == last_bit;

  wire [8:0] data_new  = nine_bit ? sh : {1'b0, sh[8:1]};
  wire       addr_mark = nine_bit ? data_new[8] : data_new[7];
  wire       stby_eff  = standby & ~(wake_sel & addr_mark);
  wire       full_eff  = rx_full & ~rd_strobe;

  assign rx_irq = rx_full & ~standby;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], line_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      prev_high <= 1'b0;
      noise_acc <= 1'b0;
      cnt       <= '0;
      smp       <= '0;
      sh        <= '0;
    end else if (tick) begin
      if (!busy) begin
        prev_high <= line_s;
        if (prev_high && !line_s) begin
          busy      <= 1'b1;
          cnt       <= 8'd1;
          noise_acc <= 1'b0;
        end
      end else begin
        cnt <= cnt + 8'd1;
        if (sample_pt) smp <= {smp[0], line_s};
        if (start_eval && maj) begin
          busy      <= 1'b0;
          prev_high <= line_s;
        end
        if (bit_eval && !done) begin
          sh        <= {maj, sh[8:1]};
          noise_acc <= noise_acc | dis;
        end
        if (done) begin
          busy      <= 1'b0;
          prev_high <= line_s;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_full   <= 1'b0;
      noise_err <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
      standby   <= 1'b0;
      idle_cnt  <= '0;
    end else begin
      if (rd_strobe) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (tick && done) begin
        if (!stby_eff && full_eff) overrun <= 1'b1;
        else begin
          rx_data   <= data_new;
          frame_err <= ~maj;
          noise_err <= noise_acc | dis;
          if (!stby_eff) rx_full <= 1'b1;
        end
        if (wake_sel && addr_mark) standby <= 1'b0;
      end
      if (stby_req) idle_cnt <= '0;
      else if (tick) begin
        if (busy || !line_s)       idle_cnt <= '0;
        else if (idle_cnt != idle_ft) idle_cnt <= idle_cnt + 8'd1;
      end
      if (tick && !busy && line_s && !wake_sel && idle_cnt == idle_ft - 8'd1)
        standby <= 1'b0;
      if (stby_req) standby <= 1'b1;
    end
  end

  a_r9_no_flag_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wake_sel && !rx_full) |=> !rx_full);
  a_r8_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rx_data));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !tick) |=> (!rx_full && !overrun));
  a_r4_no_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rx_data));
  a_r11_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> $past(tick));
  a_r2_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < 8'd171));
endmodule

// File: tb/test_uart_rx_standby.sv
module test_uart_rx_standby;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, line_in = 1'b1, nine_bit = 1'b0, wake_sel = 1'b0;
  logic stby_req = 1'b0, rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic rx_full, rx_irq, noise_err, frame_err, overrun, standby;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  uart_rx_standby i_uart_rx_standby (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .nine_bit(nine_bit), .wake_sel(wake_sel), .stby_req(stby_req),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .rx_irq(rx_irq), .noise_err(noise_err), .frame_err(frame_err),
    .overrun(overrun), .standby(standby));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    @(negedge clk) line_in = v; tick = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic pulse_stby();
    @(negedge clk) stby_req = 1'b1;
    @(negedge clk) stby_req = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input int noisy, input logic stopv, input int stop_len);
    int nb;
    nb = nine_bit ? 9 : 8;
    for (int r = 0; r < 16; r++) slot(1'b0);
    for (int b = 0; b < nb; b++)
      for (int r = 1; r <= 16; r++) slot((r == 9 && b == noisy) ? ~d[b] : d[b]);
    for (int r = 0; r < stop_len; r++) slot(stopv);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 data", rx_data, 0);
    chk("R12 full", rx_full, 0);
    chk("R12 irq", rx_irq, 0);
    chk("R12 errs", {noise_err, frame_err, overrun}, 0);
    chk("R12 standby", standby, 0);
    rst_n = 1'b1;
    idle(4);

    for (int i = 0; i < 40; i++) begin
      logic [8:0] d;
      d = 9'((i * 37 + 5) % 256);
      send(d, -1, 1'b1, 16); idle(2);
      chk("R1 data", rx_data, int'(d));
      chk("R7 full", rx_full, 1);
      chk("R7 irq", rx_irq, 1);
      chk("R3 no noise", noise_err, 0);
      chk("R5 no frame err", frame_err, 0);
      pulse_rd();
      chk("R7 read clears", rx_full, 0);
    end

    nine_bit = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [8:0] d;
      d = 9'((i * 97 + 11) % 512);
      send(d, -1, 1'b1, 16); idle(2);
      chk("R2 data", rx_data, int'(d));
      chk("R2 full", rx_full, 1);
      pulse_rd();
    end
    nine_bit = 1'b0;

    send(9'h0A5, 3, 1'b1, 16); idle(2);
    chk("R3 majority data", rx_data, 'hA5);
    chk("R3 noise flag", noise_err, 1);
    pulse_rd();

    send(9'h03C, -1, 1'b0, 16); idle(20);
    chk("R5 frame err", frame_err, 1);
    chk("R5 still loaded", rx_data, 'h3C);
    chk("R5 full", rx_full, 1);
    pulse_rd();

    for (int r = 0; r < 3; r++) slot(1'b0);
    idle(200);
    chk("R4 glitch no load", rx_full, 0);
    chk("R4 glitch data kept", rx_data, 'h3C);
    send(9'h07E, -1, 1'b1, 16); idle(2);
    chk("R4 next frame ok", rx_data, 'h7E);
    chk("R4 clean flags", {noise_err, frame_err}, 0);
    pulse_rd();

    send(9'h0C3, -1, 1'b1, 10);
    send(9'h055, -1, 1'b1, 16); idle(2);
    chk("R6 early stop frame kept", rx_data, 'hC3);
    chk("R8 overrun", overrun, 1);
    chk("R8 full", rx_full, 1);
    pulse_rd();
    chk("R8 read clears overrun", overrun, 0);

    wake_sel = 1'b1;
    send(9'h011, -1, 1'b1, 16); idle(2);
    chk("R7 irq before standby", rx_irq, 1);
    pulse_stby();
    chk("R9 standby set", standby, 1);
    chk("R9 irq masked", rx_irq, 0);
    send(9'h022, -1, 1'b1, 16); idle(2);
    chk("R9 loaded in standby", rx_data, 'h22);
    chk("R9 no overrun", overrun, 0);
    chk("R9 stays asleep", standby, 1);
    pulse_rd();
    send(9'h133, -1, 1'b1, 16); idle(2);
    chk("R10 bit8 ignored in 8-bit", standby, 1);
    chk("R9 full not set", rx_full, 0);
    chk("R9 data", rx_data, 'h33);
    send(9'h0A0, -1, 1'b1, 16); idle(2);
    chk("R10 address wake", standby, 0);
    chk("R10 full", rx_full, 1);
    chk("R10 irq", rx_irq, 1);
    chk("R10 data", rx_data, 'hA0);
    pulse_rd();

    nine_bit = 1'b1;
    pulse_stby();
    send(9'h0FF, -1, 1'b1, 16); idle(2);
    chk("R10 bit7 ignored in 9-bit", standby, 1);
    send(9'h101, -1, 1'b1, 16); idle(2);
    chk("R10 nine-bit wake", standby, 0);
    chk("R10 nine-bit data", rx_data, 'h101);
    pulse_rd();

    wake_sel = 1'b0;
    pulse_stby();
    idle(175);
    chk("R11 asleep at 175", standby, 1);
    idle(1);
    chk("R11 awake at 176", standby, 0);
    nine_bit = 1'b0;
    pulse_stby();
    idle(159);
    chk("R11 asleep at 159", standby, 1);
    idle(1);
    chk("R11 awake at 160", standby, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule